// File: doc/BRIEF.md
# Folded Halfband Low-Pass Filter

This block is a fixed 47-tap halfband low-pass filter for one real stream of 24-bit signed samples. Two instances sit side by side after a quarter-rate mixer, one for the in-phase branch and one for the quadrature branch. The filter keeps the sample rate: every accepted input sample yields exactly one filtered output sample.

The taps are mirror images about the centre, so each pair of mirrored samples is added before a single multiply. Every second tap away from the centre is zero and is left out of the structure altogether. Only twelve side products and one centre product remain. The full-precision sum is scaled down by 2^17, rounded and clipped to 24 bits. A strobe marks valid input samples, and a matching strobe marks each output. The history of samples moves only when an input sample is valid.

Top module: `hb_fir_sym`

## Requirements
- R1: Each cycle with `in_valid` high yields exactly one cycle with `out_valid` high, three clock edges later. No output strobe appears otherwise.
- R2: The impulse response over 47 outputs is symmetric about the centre tap (index 23). The centre coefficient is 131071. At odd distances 1,3,5,...,23 from the centre the coefficients are 83009, -26536, 14632, -9187, 5990, -3900, 2478, -1505, 855, -440, 194, -62. Every even nonzero distance has coefficient 0.
- R3: The output is floor((S + 2^16) / 2^17), where S is the exact sum of coefficient times sample over the 47 most recent valid samples. This rounds halves toward positive infinity.
- R4: A rounded result above 8388607 is output as 8388607, and one below -8388608 is output as -8388608.
- R5: While `in_valid` is low, `in_data` is ignored and the sample history does not move.
- R6: Synchronous active-high reset drives `out_valid` and `out_data` to 0 and fills the sample history with zeros, so the outputs after reset are computed as if zeros preceded the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Filtered sample, two's complement |

## Verification
Impulses of height 131072 make each output equal one raw coefficient. This exposes a wrong value, a misplaced pair or a non-zero even tap. Unit impulses put every output near the rounding threshold and separate correct round-half-up from truncation. Full-scale constant inputs of both signs drive the DC gain of about two into the saturation bounds. Random samples, continuous and with gaps carrying junk data, show whether the history advances only on valid strobes. A reset in mid-stream followed by an impulse shows whether the history was cleared.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int COEF_W     = 18;
    localparam int TAP_COUNT  = 47;
    localparam int GAIN_SHIFT = 17;

    localparam logic signed [COEF_W-1:0] MID_COEF = 18'sd131071;

    // Side coefficient at distance 2*idx+1 from the centre tap
    function automatic logic signed [COEF_W-1:0] side_coef(input int idx);
        case (idx)
            0:       return  18'sd83009;
            1:       return -18'sd26536;
            2:       return  18'sd14632;
            3:       return -18'sd9187;
            4:       return  18'sd5990;
            5:       return -18'sd3900;
            6:       return  18'sd2478;
            7:       return -18'sd1505;
            8:       return  18'sd855;
            9:       return -18'sd440;
            10:      return  18'sd194;
            11:      return -18'sd62;
            default: return '0;
        endcase
    endfunction

    typedef struct packed {
        logic                       vld;
        logic signed [SAMPLE_W-1:0] val;
    } smp_t;

endpackage

// File: rtl/hbf_taps.sv
module hbf_taps #(
    parameter int W     = 24,
    parameter int DEPTH = 47
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic [W-1:0]            din,
    output logic [DEPTH-1:0][W-1:0] taps,
    output logic                    taps_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps     <= '0;
            taps_vld <= 1'b0;
        end else begin
            taps_vld <= shift_en;
            if (shift_en) begin
                taps[0] <= din;
                for (int k = 1; k < DEPTH; k++) begin
                    taps[k] <= taps[k-1];
                end
            end
        end
    end

    // R6
    hist_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (taps == '0));

    // R5
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(shift_en) && !$past(rst)) |-> $stable(taps));

    // R5
    hist_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(shift_en) && !$past(rst)) |-> (taps[0] == $past(din)));

endmodule

// File: rtl/hbf_fold.sv
module hbf_fold #(
    parameter int W      = 24,
    parameter int DEPTH  = 47,
    parameter int PAIRS  = 12,
    parameter int PROD_W = 43
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DEPTH-1:0][W-1:0]  taps,
    input  logic                     taps_vld,
    output logic [PAIRS:0][PROD_W-1:0] prods,
    output logic                     prods_vld
);

    localparam int MID = (DEPTH - 1) / 2;

    genvar p;
    generate
        for (p = 0; p < PAIRS; p++) begin : g_pair
            localparam int OFF = 2 * p + 1;
            localparam int LO  = MID - OFF;
            localparam int HI  = MID + OFF;
            logic signed [W:0]        folded;
            logic signed [PROD_W-1:0] prod_q;

            assign folded = (W+1)'($signed(taps[LO])) + (W+1)'($signed(taps[HI]));

            always_ff @(posedge clk) begin
                if (rst) prod_q <= '0;
                else     prod_q <= PROD_W'(folded) * PROD_W'(hbf_pkg::side_coef(p));
            end

            assign prods[p] = prod_q;
        end
    endgenerate

    logic signed [PROD_W-1:0] mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q     <= '0;
            prods_vld <= 1'b0;
        end else begin
            mid_q     <= PROD_W'($signed(taps[MID])) * PROD_W'(hbf_pkg::MID_COEF);
            prods_vld <= taps_vld;
        end
    end

    assign prods[PAIRS] = mid_q;

endmodule

// File: rtl/hbf_accum.sv
module hbf_accum #(
    parameter int W      = 24,
    parameter int TERMS  = 13,
    parameter int PROD_W = 43,
    parameter int SHIFT  = 17
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [TERMS-1:0][PROD_W-1:0] prods,
    input  logic                       prods_vld,
    output hbf_pkg::smp_t              res
);

    localparam int ACC_W = PROD_W + $clog2(TERMS) + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(64'sd1 <<< (SHIFT-1));

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;
    logic signed [W-1:0]     clipped;

    always_comb begin
        acc = '0;
        for (int i = 0; i < TERMS; i++) begin
            acc = acc + ACC_W'($signed(prods[i]));
        end
        scaled = (acc + HALF) >>> SHIFT;
        if (scaled > SAT_HI)      clipped = SAT_HI[W-1:0];
        else if (scaled < SAT_LO) clipped = SAT_LO[W-1:0];
        else                      clipped = scaled[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.vld <= prods_vld;
            res.val <= clipped;
        end
    end

    // R4
    clip_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(scaled) > SAT_HI) |-> (res.val == SAT_HI[W-1:0]));

    // R4
    clip_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(scaled) < SAT_LO) |-> (res.val == SAT_LO[W-1:0]));

    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(scaled) <= SAT_HI && $past(scaled) >= SAT_LO)
        |-> (ACC_W'(res.val) == $past(scaled)));

endmodule

// File: rtl/hb_fir_sym.sv
module hb_fir_sym #(
    parameter int DATA_W = hbf_pkg::SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int DEPTH  = hbf_pkg::TAP_COUNT;
    localparam int PAIRS  = (DEPTH + 1) / 4;
    localparam int TERMS  = PAIRS + 1;
    localparam int PROD_W = DATA_W + 1 + hbf_pkg::COEF_W;

    logic [DEPTH-1:0][DATA_W-1:0] taps;
    logic                         taps_vld;
    logic [PAIRS:0][PROD_W-1:0]   prods;
    logic                         prods_vld;
    hbf_pkg::smp_t                res;

    hbf_taps #(.W(DATA_W), .DEPTH(DEPTH)) taps_i (
        .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_data),
        .taps(taps), .taps_vld(taps_vld)
    );

    hbf_fold #(.W(DATA_W), .DEPTH(DEPTH), .PAIRS(PAIRS), .PROD_W(PROD_W)) fold_i (
        .clk(clk), .rst(rst), .taps(taps), .taps_vld(taps_vld),
        .prods(prods), .prods_vld(prods_vld)
    );

    hbf_accum #(.W(DATA_W), .TERMS(TERMS), .PROD_W(PROD_W),
                .SHIFT(hbf_pkg::GAIN_SHIFT)) accum_i (
        .clk(clk), .rst(rst), .prods(prods), .prods_vld(prods_vld), .res(res)
    );

    assign out_valid = res.vld;
    assign out_data  = res.val;

    // R1
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R1
    no_lost_out_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
        |-> out_valid);

endmodule

// File: tb/hb_fir_sym_tb_top.sv
module hb_fir_sym_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 47;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;

    hb_fir_sym dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        longint val;
        int     at;
        string  tag;
    } exp_t;

    exp_t   q[$];
    longint hist[NT];
    int     compared = 0;
    int     mismatched = 0;

    function automatic longint ref_h(int k);
        int d;
        d = (k > 23) ? k - 23 : 23 - k;
        if (d == 0) return 131071;
        if (d % 2 == 0) return 0;
        case ((d - 1) / 2)
            0: return 83009;   1: return -26536;  2: return 14632;
            3: return -9187;   4: return 5990;    5: return -3900;
            6: return 2478;    7: return -1505;   8: return 855;
            9: return -440;    10: return 194;    default: return -62;
        endcase
    endfunction

    function automatic longint ref_out();
        longint s;
        longint r;
        s = 0;
        for (int k = 0; k < NT; k++) s += hist[k] * ref_h(k);
        r = (s + 65536) >>> 17;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic clear_hist();
        for (int k = 0; k < NT; k++) hist[k] = 0;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic send(input longint v, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v[23:0];
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
        e.val = ref_out();
        e.at  = cyc + 3;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 24'($urandom);
        end
    endtask

    function automatic longint rnd24();
        logic [23:0] r;
        r = 24'($urandom);
        return longint'($signed(r));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_hist();
        // R6: outputs cleared by reset
        check(out_valid == 1'b0, "R6 out_valid after reset", longint'(out_valid), 0);
        check(out_data == 24'd0, "R6 out_data after reset", longint'(out_data), 0);
    endtask

    // Monitor: pops expectations in order as outputs appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R1 unexpected output strobe", longint'($signed(out_data)), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.at, {e.tag, " R1 latency"}, cyc, e.at);
                check(longint'($signed(out_data)) == e.val, e.tag,
                      longint'($signed(out_data)), e.val);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        clear_hist();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6 reset state
        check(out_valid == 1'b0, "R6 out_valid at reset", longint'(out_valid), 0);
        check(out_data == 24'd0, "R6 out_data at reset", longint'(out_data), 0);

        // R2: impulse of 2^17 reproduces each coefficient
        send(131072, "R2 coefficient impulse");
        for (int i = 0; i < 50; i++) send(0, "R2 coefficient impulse");
        send(-131072, "R2 negative impulse");
        for (int i = 0; i < 50; i++) send(0, "R2 negative impulse");
        idle(5);

        // R3: unit and small impulses straddle the rounding threshold
        send(1, "R3 unit impulse");
        for (int i = 0; i < 48; i++) send(0, "R3 unit impulse");
        send(-1, "R3 negative unit impulse");
        for (int i = 0; i < 48; i++) send(0, "R3 negative unit impulse");
        send(3, "R3 small impulse");
        for (int i = 0; i < 48; i++) send(0, "R3 small impulse");

        // R4: full-scale DC of both signs saturates
        for (int i = 0; i < 60; i++) send(8388607, "R4 positive saturation");
        for (int i = 0; i < 60; i++) send(-8388608, "R4 negative saturation");
        for (int i = 0; i < 50; i++) send(0, "R4 recovery");

        // R1/R3: continuous random stream
        for (int i = 0; i < 300; i++) send(rnd24(), "R1 R3 random stream");

        // R5: gaps with junk data on the input
        for (int i = 0; i < 200; i++) begin
            send(rnd24() >>> 2, "R5 gapped stream");
            idle(int'($urandom_range(0, 3)));
        end
        idle(10);
        check(q.size() == 0, "R1 all outputs delivered", q.size(), 0);

        // R6: reset in mid-stream clears the history
        for (int i = 0; i < 30; i++) send(rnd24(), "R6 pre-reset data");
        idle(10);
        do_reset();
        send(131072, "R6 impulse after reset");
        for (int i = 0; i < 50; i++) send(0, "R6 impulse after reset");
        idle(10);
        check(q.size() == 0, "R1 all outputs delivered at end", q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule